// File: doc/BRIEF.md
# Dual-Clock FIFO with Bus-Loaded Flag Thresholds

This block is a 9-bit, dual-clock first-in first-out buffer. Its depth is a parameter: a power of two, at least 256, with 256 as the default. Words are pushed on the write clock and popped on the read clock. Four status flags report the fill level. Empty and almost-empty are registered in the read clock domain. Full and almost-full are registered in the write clock domain.

The two almost-flag thresholds are not fixed parameters. They live in four offset fields. These fields are written through the same 9-bit data bus that carries array words, and read back through the read data path. The `fifo_sel` pin chooses the target. When it is high, accepted traffic goes to the array. When it is low, traffic goes to the offset fields, which are visited in a fixed rotation of four slots:

- slot 0: almost-empty threshold, low byte
- slot 1: almost-empty threshold, upper bits
- slot 2: almost-full threshold, low byte
- slot 3: almost-full threshold, upper bits

The thresholds are meant to be set while the FIFO is idle.

The write side is a valid/ready stream. A word is taken on a write-clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` falls while the array is full and `fifo_sel` is high. In offset mode it stays high. The read side is a pull interface. `rd_ready` requests one read per read-clock edge. The request takes effect only if the selected source can supply a word. `rd_valid` then pulses for one cycle, with the word on `rd_data`, after the edge that performed the read. A consumer must hold `rd_ready` low when it cannot take a word in the next cycle.

Top module: `fifo_ofs`

## Requirements
- R1: With `fifo_sel`=1, every write accepted on a write-clock edge stores `wr_data`. Accepted reads return the stored words in write order.
- R2: With `fifo_sel`=0 and `wr_valid`=1, each write-clock edge writes into the next offset slot and leaves the array untouched. Slot 0 takes `wr_data[7:0]` as the almost-empty low byte. Slot 1 takes `wr_data[AW-9:0]` as the almost-empty upper bits. Slot 2 takes `wr_data[7:0]` as the almost-full low byte. Slot 3 takes `wr_data[AW-9:0]` as the almost-full upper bits. After slot 3 the rotation returns to slot 0. AW is log2(DEPTH).
- R3: While `wr_valid`=0, no write-clock edge changes the array, the offsets or the load slot, in either mode.
- R4: With `fifo_sel`=0 and `rd_ready`=1, each read-clock edge places the next slot's field on `rd_data`, using the same slot order, and raises `rd_valid` for one cycle. Bit 8 reads 0, and so does every upper bit that the depth does not need. With DEPTH=256 the upper slots read 0.
- R5: If an offset read and an offset write are requested at the same edge, the read is ignored. `rd_valid` stays low and the readback slot does not advance.
- R6: After reset, `empty`=1, `almost_empty`=1, `full`=0, `almost_full`=0 and `rd_valid`=0. Both thresholds are 7, and both rotations start at slot 0.
- R7: With no reads after reset, `full` rises after exactly DEPTH accepted writes. While `full`=1 and `fifo_sel`=1, `wr_ready`=0 and no write advances the write pointer.
- R8: `empty` is 1 when the read pointer, as seen in the read domain, equals the write pointer. While it is 1, array reads are refused and `rd_valid` stays low.
- R9: `almost_empty` is 1 when the word count is at most the almost-empty threshold. `almost_full` is 1 when the free space is at most the almost-full threshold. `full` implies `almost_full`, and `empty` implies `almost_empty`.
- R10: Flags change only on their own clock's rising edge. With a common clock, a write into an empty FIFO clears `empty` on the third read edge after the write edge.
- R11: The stored count never exceeds DEPTH. Each edge moves a pointer by at most one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| fifo_sel | input | 1 | 1: array traffic, 0: offset field traffic |
| wr_valid | input | 1 | Write request (write enable) |
| wr_ready | output | 1 | Write can be accepted |
| wr_data | input | 9 | Write data or offset field |
| rd_ready | input | 1 | Read request (read enable) |
| rd_valid | output | 1 | `rd_data` holds a freshly read word this cycle |
| rd_data | output | 9 | Read word or offset field |
| full | output | 1 | Array full (write domain) |
| empty | output | 1 | Array empty (read domain) |
| almost_full | output | 1 | Free space at or below the almost-full threshold |
| almost_empty | output | 1 | Count at or below the almost-empty threshold |

## Verification
The checker enforces these rules on every cycle, both in array mode and in offset mode:

- a full array refuses writes and an empty array refuses reads
- the full and empty flags imply their almost counterparts
- occupancy stays within DEPTH
- pointers move at most one step per edge
- the load slot advances exactly when an offset write occurs
- a conflicting offset read never yields `rd_valid`

Other behaviour needs the bench scenarios:

- data ordering through the array
- the exact threshold values seen after loading, including masking of bit 8
- the readback slot staying put after an ignored read
- full arriving after precisely DEPTH writes
- the three-edge flag lag

// File: rtl/fifo_ofs_pkg.sv
package fifo_ofs_pkg;
  localparam int unsigned WORD_W = 9;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned RESET_THRESH = 7;

  typedef enum logic [1:0] {
    SLOT_AE_LO = 2'd0,
    SLOT_AE_HI = 2'd1,
    SLOT_AF_LO = 2'd2,
    SLOT_AF_HI = 2'd3
  } ofs_slot_e;
endpackage

// File: rtl/fifo_ofs_gsync.sv
// Two-flop synchronizer for a Gray-coded pointer; converts back to binary.
module fifo_ofs_gsync #(
  parameter int unsigned W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] bin_out
);
  logic [W-1:0] s1, s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= gray_in;
      s2 <= s1;
    end
  end

  always_comb begin
    logic [W-1:0] acc;
    acc[W-1] = s2[W-1];
    for (int i = int'(W) - 2; i >= 0; i--) acc[i] = acc[i+1] ^ s2[i];
    bin_out = acc;
  end
endmodule

// File: rtl/fifo_ofs_bank.sv
// Threshold storage: loaded in rotation on the write clock, read via a slot mux.
module fifo_ofs_bank
  import fifo_ofs_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [WORD_W-1:0] din,
  input  ofs_slot_e         rb_slot,
  output ofs_slot_e         ld_slot,
  output logic [AW-1:0]     ae_thresh,
  output logic [AW-1:0]     af_thresh,
  output logic [WORD_W-1:0] rb_data
);
  localparam int unsigned HI_W = AW - BYTE_W;

  logic [BYTE_W-1:0] ae_lo, af_lo;
  logic [WORD_W-1:0] ae_hi_rb, af_hi_rb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ae_lo   <= BYTE_W'(RESET_THRESH);
      af_lo   <= BYTE_W'(RESET_THRESH);
      ld_slot <= SLOT_AE_LO;
    end else if (ld_en) begin
      if (ld_slot == SLOT_AE_LO) ae_lo <= din[BYTE_W-1:0];
      if (ld_slot == SLOT_AF_LO) af_lo <= din[BYTE_W-1:0];
      ld_slot <= ofs_slot_e'(ld_slot + 2'd1);
    end
  end

  generate
    if (HI_W > 0) begin : g_hi
      logic [HI_W-1:0] ae_hi, af_hi;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ae_hi <= '0;
          af_hi <= '0;
        end else if (ld_en) begin
          if (ld_slot == SLOT_AE_HI) ae_hi <= din[HI_W-1:0];
          if (ld_slot == SLOT_AF_HI) af_hi <= din[HI_W-1:0];
        end
      end
      assign ae_thresh = {ae_hi, ae_lo};
      assign af_thresh = {af_hi, af_lo};
      assign ae_hi_rb  = WORD_W'(ae_hi);
      assign af_hi_rb  = WORD_W'(af_hi);
    end else begin : g_nohi
      assign ae_thresh = AW'(ae_lo);
      assign af_thresh = AW'(af_lo);
      assign ae_hi_rb  = '0;
      assign af_hi_rb  = '0;
    end
  endgenerate

  always_comb begin
    unique case (rb_slot)
      SLOT_AE_LO: rb_data = {1'b0, ae_lo};
      SLOT_AE_HI: rb_data = ae_hi_rb;
      SLOT_AF_LO: rb_data = {1'b0, af_lo};
      default:    rb_data = af_hi_rb;
    endcase
  end
endmodule

// File: rtl/fifo_ofs_wside.sv
// Write pointer, full and almost-full, all in the write domain.
module fifo_ofs_wside #(
  parameter int unsigned AW = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        push,
  input  logic [AW:0] rsync_bin,
  input  logic [AW-1:0] af_thresh,
  output logic [AW:0] wptr_bin,
  output logic [AW:0] wptr_gray,
  output logic        full,
  output logic        afull
);
  localparam logic [AW:0] CAP = (AW+1)'(1) << AW;

  logic [AW:0] wnext, wcnt, wfree;
  assign wnext = wptr_bin + (AW+1)'(push);
  assign wcnt  = wnext - rsync_bin;
  assign wfree = CAP - wcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_bin  <= '0;
      wptr_gray <= '0;
      full      <= 1'b0;
      afull     <= 1'b0;
    end else begin
      wptr_bin  <= wnext;
      wptr_gray <= wnext ^ (wnext >> 1);
      full      <= (wcnt == CAP);
      afull     <= (wfree <= {1'b0, af_thresh});
    end
  end
endmodule

// File: rtl/fifo_ofs_rside.sv
// Read pointer, empty and almost-empty, output register and readback slot.
module fifo_ofs_rside
  import fifo_ofs_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pop,
  input  logic              ofs_rd,
  input  logic [AW:0]       wsync_bin,
  input  logic [AW-1:0]     ae_thresh,
  input  logic [WORD_W-1:0] mem_q,
  input  logic [WORD_W-1:0] rb_data,
  output ofs_slot_e         rb_slot,
  output logic [AW:0]       rptr_bin,
  output logic [AW:0]       rptr_gray,
  output logic              empty,
  output logic              aempty,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data
);
  logic [AW:0] rnext, rcnt;
  assign rnext = rptr_bin + (AW+1)'(pop);
  assign rcnt  = wsync_bin - rnext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr_bin  <= '0;
      rptr_gray <= '0;
      empty     <= 1'b1;
      aempty    <= 1'b1;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
      rb_slot   <= SLOT_AE_LO;
    end else begin
      rptr_bin  <= rnext;
      rptr_gray <= rnext ^ (rnext >> 1);
      empty     <= (rcnt == '0);
      aempty    <= (rcnt <= {1'b0, ae_thresh});
      rd_valid  <= pop | ofs_rd;
      if (pop) begin
        rd_data <= mem_q;
      end else if (ofs_rd) begin
        rd_data <= rb_data;
        rb_slot <= ofs_slot_e'(rb_slot + 2'd1);
      end
    end
  end
endmodule

// File: rtl/fifo_ofs.sv
module fifo_ofs
  import fifo_ofs_pkg::*;
#(
  parameter int unsigned DEPTH = 256
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              rst_n,
  input  logic              fifo_sel,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_ready,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data,
  output logic              full,
  output logic              empty,
  output logic              almost_full,
  output logic              almost_empty
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW:0]       wptr_bin, wptr_gray, rptr_bin, rptr_gray;
  logic [AW:0]       rsync_bin, wsync_bin;
  logic [AW-1:0]     ae_thresh, af_thresh;
  logic [WORD_W-1:0] rb_data, mem_q;
  ofs_slot_e         ld_slot, rb_slot;
  logic              push, pop, ofs_wr, ofs_rd;

  assign wr_ready = fifo_sel ? ~full : 1'b1;
  assign push     = wr_valid & fifo_sel & ~full;
  assign ofs_wr   = wr_valid & ~fifo_sel;
  assign pop      = rd_ready & fifo_sel & ~empty;
  assign ofs_rd   = rd_ready & ~fifo_sel & ~wr_valid;
  assign mem_q    = mem[rptr_bin[AW-1:0]];

  always_ff @(posedge wclk) begin
    if (push) mem[wptr_bin[AW-1:0]] <= wr_data;
  end

  fifo_ofs_bank #(.AW(AW)) u_bank (
    .clk(wclk), .rst_n(rst_n), .ld_en(ofs_wr), .din(wr_data),
    .rb_slot(rb_slot), .ld_slot(ld_slot), .ae_thresh(ae_thresh),
    .af_thresh(af_thresh), .rb_data(rb_data)
  );

  fifo_ofs_gsync #(.W(AW+1)) u_rsync (
    .clk(wclk), .rst_n(rst_n), .gray_in(rptr_gray), .bin_out(rsync_bin)
  );

  fifo_ofs_gsync #(.W(AW+1)) u_wsync (
    .clk(rclk), .rst_n(rst_n), .gray_in(wptr_gray), .bin_out(wsync_bin)
  );

  fifo_ofs_wside #(.AW(AW)) u_wside (
    .clk(wclk), .rst_n(rst_n), .push(push), .rsync_bin(rsync_bin),
    .af_thresh(af_thresh), .wptr_bin(wptr_bin), .wptr_gray(wptr_gray),
    .full(full), .afull(almost_full)
  );

  fifo_ofs_rside #(.AW(AW)) u_rside (
    .clk(rclk), .rst_n(rst_n), .pop(pop), .ofs_rd(ofs_rd),
    .wsync_bin(wsync_bin), .ae_thresh(ae_thresh), .mem_q(mem_q),
    .rb_data(rb_data), .rb_slot(rb_slot), .rptr_bin(rptr_bin),
    .rptr_gray(rptr_gray), .empty(empty), .aempty(almost_empty),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );
endmodule

// File: rtl/fifo_ofs_chk.sv
module fifo_ofs_chk #(
  parameter int unsigned AW = 8
) (
  input logic        wclk,
  input logic        rclk,
  input logic        rst_n,
  input logic        fifo_sel,
  input logic        wr_valid,
  input logic        rd_ready,
  input logic        rd_valid,
  input logic        full,
  input logic        empty,
  input logic        almost_full,
  input logic        almost_empty,
  input logic [AW:0] wptr_bin,
  input logic [AW:0] rptr_bin,
  input logic [AW:0] rsync_bin,
  input logic [1:0]  ld_slot
);
  localparam logic [AW:0] CAP = (AW+1)'(1) << AW;

  // R7
  full_blocks_write_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    (full && fifo_sel && wr_valid) |=> (wptr_bin == $past(wptr_bin)));

  // R8
  empty_blocks_read_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    (empty && fifo_sel && rd_ready) |=> (rptr_bin == $past(rptr_bin)));

  // R9
  full_implies_afull_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    full |-> almost_full);

  // R9
  empty_implies_aempty_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    empty |-> almost_empty);

  // R11
  occupancy_bound_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    (wptr_bin - rsync_bin) <= CAP);

  // R11
  wptr_step_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    1'b1 |=> ((wptr_bin - $past(wptr_bin)) <= (AW+1)'(1)));

  // R2
  slot_advance_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    (!fifo_sel && wr_valid) |=> (ld_slot == $past(ld_slot) + 2'd1));

  // R3
  idle_write_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    (!wr_valid) |=> ($stable(ld_slot) && $stable(wptr_bin)));

  // R5
  conflict_read_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    (!fifo_sel && wr_valid && rd_ready) |=> !rd_valid);
endmodule

bind fifo_ofs fifo_ofs_chk #(.AW(AW)) u_chk (
  .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .fifo_sel(fifo_sel),
  .wr_valid(wr_valid), .rd_ready(rd_ready), .rd_valid(rd_valid),
  .full(full), .empty(empty), .almost_full(almost_full),
  .almost_empty(almost_empty), .wptr_bin(wptr_bin), .rptr_bin(rptr_bin),
  .rsync_bin(rsync_bin), .ld_slot(ld_slot)
);

// File: tb/fifo_ofs_bench.sv
module fifo_ofs_bench;
  localparam int DEPTH = 256;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fifo_sel = 1'b1, wr_valid = 1'b0, rd_ready = 1'b0;
  logic [8:0] wr_data = '0;
  logic       wr_ready, rd_valid, full, empty, almost_full, almost_empty;
  logic [8:0] rd_data;

  int vectors = 0, miscompares = 0;
  int ae_m = 7, af_m = 7;
  int q[$];
  bit done = 0;

  always #2 clk = ~clk;

  fifo_ofs #(.DEPTH(DEPTH)) u_fifo_ofs (
    .wclk(clk), .rclk(clk), .rst_n(rst_n), .fifo_sel(fifo_sel),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_data(rd_data),
    .full(full), .empty(empty), .almost_full(almost_full),
    .almost_empty(almost_empty)
  );

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_aempty(int n); return (n <= ae_m) ? 1 : 0; endfunction
  function automatic int exp_afull(int n); return ((DEPTH - n) <= af_m) ? 1 : 0; endfunction

  // One array-mode cycle; acceptance follows the flags seen before the edge.
  task automatic step(input bit wv, input bit rr, input logic [8:0] d);
    bit wacc, racc;
    fifo_sel = 1'b1; wr_valid = wv; rd_ready = rr; wr_data = d;
    wacc = wv && wr_ready;
    racc = rr && !empty;
    @(negedge clk);
    if (racc) begin
      check("R1 rd_valid", rd_valid, 1);
      check("R1 data order", rd_data, q.pop_front());
    end else begin
      check("R8 no read", rd_valid, 0);
    end
    if (wacc) q.push_back(d);
    wr_valid = 1'b0; rd_ready = 1'b0;
  endtask

  task automatic settle_check(input string tag);
    wr_valid = 1'b0; rd_ready = 1'b0;
    repeat (6) @(negedge clk);
    check({"R8 empty ", tag}, empty, (q.size() == 0) ? 1 : 0);
    check({"R7 full ", tag}, full, (q.size() == DEPTH) ? 1 : 0);
    check({"R9 almost_empty ", tag}, almost_empty, exp_aempty(q.size()));
    check({"R9 almost_full ", tag}, almost_full, exp_afull(q.size()));
  endtask

  task automatic ofs_write(input logic [8:0] d);
    fifo_sel = 1'b0; wr_valid = 1'b1; rd_ready = 1'b0; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0; fifo_sel = 1'b1;
  endtask

  task automatic ofs_read(input int exp, input string req);
    fifo_sel = 1'b0; wr_valid = 1'b0; rd_ready = 1'b1;
    @(negedge clk);
    check({req, " readback valid"}, rd_valid, 1);
    check({req, " readback value"}, rd_data, exp);
    rd_ready = 1'b0; fifo_sel = 1'b1;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R6 reset state
    check("R6 empty", empty, 1);
    check("R6 almost_empty", almost_empty, 1);
    check("R6 full", full, 0);
    check("R6 almost_full", almost_full, 0);
    check("R6 rd_valid", rd_valid, 0);
    check("R6 wr_ready", wr_ready, 1);
    // R6/R4 default thresholds read back in slot order
    ofs_read(7, "R6"); ofs_read(0, "R6"); ofs_read(7, "R6"); ofs_read(0, "R6");

    // R10 flag lag: write edge k, empty clears on edge k+3
    fifo_sel = 1'b1; wr_valid = 1'b1; wr_data = 9'h0AB;
    @(negedge clk); q.push_back(9'h0AB); wr_valid = 1'b0;
    @(negedge clk);
    check("R10 empty still set", empty, 1);
    repeat (2) @(negedge clk);
    check("R10 empty cleared", empty, 0);
    step(0, 1, '0);
    settle_check("after R10");

    // R2 load thresholds; bit 8 and unused upper bits are dropped (R4)
    ofs_write(9'h114); ofs_write(9'h1FF); ofs_write(9'd30); ofs_write(9'd3);
    ae_m = 20; af_m = 30;
    settle_check("R2 array untouched");
    // R3 idle cycles with offset mode selected change nothing
    fifo_sel = 1'b0;
    for (int i = 0; i < 5; i++) begin wr_data = 9'(i * 37); @(negedge clk); end
    fifo_sel = 1'b1;
    ofs_read(20, "R4 R3"); ofs_read(0, "R4 R3"); ofs_read(30, "R4 R3"); ofs_read(0, "R4 R3");

    // R5 conflict: write lands in slot 0, read ignored
    fifo_sel = 1'b0; wr_valid = 1'b1; rd_ready = 1'b1; wr_data = 9'd5;
    @(negedge clk);
    check("R5 conflicting read ignored", rd_valid, 0);
    wr_valid = 1'b0; rd_ready = 1'b0; fifo_sel = 1'b1;
    ofs_write(9'd0); ofs_write(9'd30); ofs_write(9'd0);
    ae_m = 5;
    ofs_read(5, "R5 slot held"); ofs_read(0, "R5"); ofs_read(30, "R5"); ofs_read(0, "R5");

    // R7 fill to exactly DEPTH
    for (int i = 0; i < DEPTH - 1; i++) step(1, 0, 9'($urandom));
    settle_check("one short of full");
    step(1, 0, 9'h155);
    settle_check("at DEPTH");
    check("R7 wr_ready low when full", wr_ready, 0);
    step(1, 0, 9'h0FF);
    settle_check("blocked write");
    // R1 drain in order, then R8 read of empty array refused
    for (int i = 0; i < DEPTH; i++) step(0, 1, '0);
    settle_check("drained");
    for (int i = 0; i < 3; i++) step(0, 1, '0);

    // Random array traffic in write-heavy and read-heavy phases
    for (int ph = 0; ph < 12; ph++) begin
      int wp = (ph % 2 == 0) ? 80 : 30;
      for (int c = 0; c < 200; c++)
        step(($urandom % 100) < wp, ($urandom % 100) < (110 - wp), 9'($urandom));
      settle_check("random phase");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule